// File: doc/BRIEF.md
# Backplane Reset Pulse-Width Classifier

This block watches an active-low backplane reset wire and sorts every low pulse on it by how long it lasts. A pulse that ends before the initialize threshold leaves every output untouched. A pulse held past the initialize threshold raises a bus-initialize output. A pulse held past the much longer system threshold also raises a system-reset output. Both outputs drop a short, fixed delay after the wire returns high.

Alongside those two outputs the block drives two signals toward the bus arbiter. The first is a grant inhibit, which has the same effect on new grants as withdrawing the arbiter's enable. The second is a forced-preemption request. The inhibit rises with bus-initialize and the forced preemption rises with system-reset. Both stay up until the wire has been continuously high for a longer recovery interval. If the wire dips low again inside that interval, the recovery interval starts over.

All thresholds are given in nanoseconds together with the clock frequency in kHz, and the block converts them to cycle counts at elaboration. The wire passes through a two-flop synchronizer. One saturating counter measures low time and a second measures high time.

Top module: `rst_pulse_classifier`

## Requirements
- R1: After the synchronous reset, the wire is treated as released and bus_init, sys_reset, grant_block and force_preempt are all 0.
- R2: A low pulse shorter than the initialize threshold (INIT_NS) raises none of the four outputs.
- R3: When the wire is held low past INIT_NS, bus_init goes to 1 while sys_reset stays 0 until the system threshold is reached.
- R4: When the wire is held low past the system threshold (RST_NS), sys_reset goes to 1, and bus_init is 1 for as long as sys_reset is 1.
- R5: After the wire returns high, bus_init and sys_reset fall within about DROP_NS plus two synchronizer cycles, and they stay 1 before that point.
- R6: grant_block is 1 whenever bus_init is 1, and it stays 1 after release until the wire has been high for REEN_NS.
- R7: force_preempt is 1 whenever sys_reset is 1, and it stays 1 after release until the wire has been high for REEN_NS.
- R8: A pulse that reaches INIT_NS but not RST_NS never raises sys_reset or force_preempt.
- R9: If the wire goes low again before REEN_NS of high time has passed, the recovery interval restarts from that later release. grant_block stays 1 throughout, and a short dip does not raise bus_init again.
- R10: A low pulse far longer than RST_NS keeps bus_init and sys_reset at 1 without interruption, because the low-time counter saturates instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_KHZ |
| rst | input | 1 | Synchronous active-high reset |
| line_n | input | 1 | Backplane reset wire, active low, asynchronous |
| bus_init | output | 1 | Bus-initialize indication, active high |
| sys_reset | output | 1 | System-reset indication, active high |
| grant_block | output | 1 | Inhibit new grants at the arbiter, active high |
| force_preempt | output | 1 | Force the arbiter's preemption signal, active high |

## Verification
The assertions assume that the wire, once low, stays low for at least a few cycles, so that a rise of bus_init can be traced back to a low level three cycles earlier. They also assume that the thresholds are ordered: drop delay below recovery time, and initialize threshold below system threshold. The stimulus only changes line_n on falling clock edges and holds every pulse for tens of cycles or more. It uses scaled-down thresholds that keep these orderings. Every sample is taken with a margin of many cycles from the expected transition, so synchronizer latency cannot change the outcome.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Convert a duration in ns to clock cycles at the given clock in kHz.
  function automatic longint ns_to_cycles(input longint ns, input longint khz);
    return (ns * khz) / 64'd1_000_000;
  endfunction

  // Width able to hold 0..max_val.
  function automatic int cnt_width(input longint max_val);
    int w;
    w = 1;
    while ((64'd1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= INIT;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwc_sat_timer.sv
module pwc_sat_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] LIMIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || !run)       count <= '0;
    else if (count != LIMIT) count <= count + 1'b1;
  end
endmodule

// File: rtl/rst_pulse_classifier.sv
module rst_pulse_classifier #(
  parameter int CLK_KHZ     = 125_000,
  parameter int SYNC_STAGES = 2,
  parameter longint INIT_NS = 3_000_000,
  parameter longint RST_NS  = 45_000_000,
  parameter longint DROP_NS = 100,
  parameter longint REEN_NS = 1_600
) (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic bus_init,
  output logic sys_reset,
  output logic grant_block,
  output logic force_preempt
);
  import pwc_pkg::*;

  localparam longint INIT_CYC = ns_to_cycles(INIT_NS, longint'(CLK_KHZ));
  localparam longint RST_CYC  = ns_to_cycles(RST_NS,  longint'(CLK_KHZ));
  localparam longint DROP_CYC = ns_to_cycles(DROP_NS, longint'(CLK_KHZ));
  localparam longint REEN_CYC = ns_to_cycles(REEN_NS, longint'(CLK_KHZ));
  localparam int LO_W = cnt_width(RST_CYC);
  localparam int HI_W = cnt_width(REEN_CYC);
  localparam logic [LO_W-1:0] LO_INIT = LO_W'(INIT_CYC);
  localparam logic [LO_W-1:0] LO_RST  = LO_W'(RST_CYC);
  localparam logic [HI_W-1:0] HI_DROP = HI_W'(DROP_CYC);
  localparam logic [HI_W-1:0] HI_REEN = HI_W'(REEN_CYC);

  logic            line_q;
  logic            line_low;
  logic [LO_W-1:0] low_time;
  logic [HI_W-1:0] high_time;
  logic            hit_init, hit_rst, past_drop, past_reen;

  pwc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(line_n), .q(line_q)
  );

  assign line_low = ~line_q;

  pwc_sat_timer #(.W(LO_W), .LIMIT(LO_RST)) u_low_timer (
    .clk(clk), .rst(rst), .run(line_low), .count(low_time)
  );

  pwc_sat_timer #(.W(HI_W), .LIMIT(HI_REEN)) u_high_timer (
    .clk(clk), .rst(rst), .run(line_q), .count(high_time)
  );

  assign hit_init  = line_low && (low_time >= LO_INIT);
  assign hit_rst   = line_low && (low_time == LO_RST);
  assign past_drop = line_q && (high_time >= HI_DROP);
  assign past_reen = line_q && (high_time == HI_REEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_init      <= 1'b0;
      sys_reset     <= 1'b0;
      grant_block   <= 1'b0;
      force_preempt <= 1'b0;
    end else begin
      if (hit_init)       bus_init <= 1'b1;
      else if (past_drop) bus_init <= 1'b0;

      if (hit_rst)        sys_reset <= 1'b0 | 1'b1;
      else if (past_drop) sys_reset <= 1'b0;

      if (hit_init)       grant_block <= 1'b1;
      else if (past_reen) grant_block <= 1'b0;

      if (hit_rst)        force_preempt <= 1'b1;
      else if (past_reen) force_preempt <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_pulse_classifier_chk.sv
module rst_pulse_classifier_chk (
  input logic clk,
  input logic rst,
  input logic line_n,
  input logic bus_init,
  input logic sys_reset,
  input logic grant_block,
  input logic force_preempt
);
  // R4
  sysrst_needs_init_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset |-> bus_init);

  // R6
  init_blocks_grants_chk: assert property (@(posedge clk) disable iff (rst)
    bus_init |-> grant_block);

  // R7
  sysrst_forces_pe_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset |-> force_preempt);

  // R3
  init_rise_from_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_init) |-> ($past(line_n, 3) == 1'b0));

  // R7
  pe_release_after_sysrst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(force_preempt) |-> !sys_reset && line_n);

  // R6
  block_release_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_block) |-> !bus_init && line_n);
endmodule

bind rst_pulse_classifier rst_pulse_classifier_chk u_chk (
  .clk(clk), .rst(rst), .line_n(line_n), .bus_init(bus_init),
  .sys_reset(sys_reset), .grant_block(grant_block), .force_preempt(force_preempt)
);

// File: tb/test_rst_pulse_classifier.sv
module test_rst_pulse_classifier;
  // Scaled thresholds at 125 MHz: init 375 cyc, rst 2500 cyc, drop 12 cyc, reen 200 cyc.
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_n = 1'b1;
  logic bus_init, sys_reset, grant_block, force_preempt;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_pulse_classifier #(
    .CLK_KHZ(125_000), .SYNC_STAGES(2),
    .INIT_NS(3_000), .RST_NS(20_000), .DROP_NS(100), .REEN_NS(1_600)
  ) i_rst_pulse_classifier (
    .clk(clk), .rst(rst), .line_n(line_n), .bus_init(bus_init),
    .sys_reset(sys_reset), .grant_block(grant_block), .force_preempt(force_preempt)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input logic [3:0] exp, input string req, input string what);
    chk(bus_init, exp[3], req, {what, " bus_init"});
    chk(sys_reset, exp[2], req, {what, " sys_reset"});
    chk(grant_block, exp[1], req, {what, " grant_block"});
    chk(force_preempt, exp[0], req, {what, " force_preempt"});
  endtask

  task automatic t_reset;
    cyc(5);
    chk_all(4'b0000, "R1", "in reset");
    rst = 1'b0;
    cyc(20);
    chk_all(4'b0000, "R1", "after reset");
  endtask

  task automatic t_short;
    line_n = 1'b0;
    cyc(300);
    chk_all(4'b0000, "R2", "short low");
    line_n = 1'b1;
    cyc(300);
    chk_all(4'b0000, "R2", "short released");
  endtask

  task automatic t_medium;
    line_n = 1'b0;
    cyc(340);
    chk(bus_init, 1'b0, "R3", "before init threshold");
    cyc(100);
    chk_all(4'b1010, "R3", "medium held");
    cyc(560);
    chk_all(4'b1010, "R8", "medium long held");
    line_n = 1'b1;
    cyc(4);
    chk(bus_init, 1'b1, "R5", "init just after release");
    cyc(26);
    chk_all(4'b0010, "R5", "init dropped, block held");
    cyc(120);
    chk(grant_block, 1'b1, "R6", "block before reen");
    cyc(110);
    chk_all(4'b0000, "R6", "block cleared");
  endtask

  task automatic t_long;
    line_n = 1'b0;
    cyc(2400);
    chk_all(4'b1010, "R4", "before rst threshold");
    cyc(200);
    chk_all(4'b1111, "R4", "past rst threshold");
    line_n = 1'b1;
    cyc(4);
    chk(sys_reset, 1'b1, "R5", "sys_reset just after release");
    cyc(26);
    chk_all(4'b0011, "R7", "outputs dropped, pe held");
    cyc(120);
    chk(force_preempt, 1'b1, "R7", "pe before reen");
    cyc(110);
    chk_all(4'b0000, "R7", "pe cleared");
  endtask

  task automatic t_restart;
    line_n = 1'b0;
    cyc(500);
    line_n = 1'b1;
    cyc(100);
    line_n = 1'b0;
    cyc(50);
    chk(bus_init, 1'b0, "R9", "dip no init");
    line_n = 1'b1;
    cyc(150);
    chk(grant_block, 1'b1, "R9", "block held after restart");
    cyc(110);
    chk_all(4'b0000, "R9", "block cleared after restarted window");
  endtask

  task automatic t_saturate;
    bit gap;
    gap = 1'b0;
    line_n = 1'b0;
    cyc(2600);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!(bus_init && sys_reset)) gap = 1'b1;
    end
    chk(gap, 1'b0, "R10", "no dropout in long pulse");
    chk_all(4'b1111, "R10", "end of long pulse");
    line_n = 1'b1;
    cyc(300);
    chk_all(4'b0000, "R10", "after long pulse");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_short();
    t_medium();
    t_long();
    t_restart();
    t_saturate();
    finish_run();
  end

  initial begin
    #(200_000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule